// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one READ or WRITE command into the list of column addresses for its burst. When the command arrives it captures the start column, the burst-length code and the ordering bit from the mode register settings. It then emits one column address per clock beat. It flags the final beat and stops, unless another command takes over first.

The burst covers 2, 4 or 8 locations. That block of columns is naturally aligned, and the address always wraps inside it. In sequential order the low address bits count upward from the start column and wrap around. In interleaved order the low bits are the start bits XORed with the beat number. Column bits above the block never change during a burst. Because the DRAM core moves two beats per internal access, every legal burst has an even number of beats.

Top module: `burst_col_gen`

## Requirements
- R1: While rst_ni is low and after its release, with no start given, valid_o and last_o are 0.
- R2: A start with len_code_i 3'b001, 3'b010 or 3'b011 produces a burst of 2, 4 or 8 beats. valid_o is high for exactly that many consecutive cycles, beginning the cycle after the start.
- R3: A start with any other len_code_i (3'b000 or 3'b100 to 3'b111) is ignored. From idle, no burst begins. During a burst, the running burst continues with its own addresses.
- R4: The first beat, one cycle after an accepted start, presents col_i exactly as it was sampled with the start.
- R5: With order_i = 0 (sequential), the low log2(BL) bits on beat k are (start low bits + k) mod BL.
- R6: With order_i = 1 (interleaved), the low log2(BL) bits on beat k are the start low bits XOR k.
- R7: Column bits at or above log2(BL) stay equal to the start column on every beat of the burst.
- R8: last_o is high only on the final beat. On the cycle after that, valid_o is 0 unless an accepted start came with the final beat.
- R9: An accepted start during a burst ends that burst. Beat 0 of the new sequence appears on the next cycle.
- R10: An accepted start on the final beat gives a gap-free continuation into the new burst.
- R11: len_code_i, order_i and col_i are sampled only with an accepted start. Changing them during a burst has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command strobe, one cycle |
| col_i | input | COL_W | Start column of the command |
| len_code_i | input | 3 | Burst-length code: 001=2, 010=4, 011=8, others reserved |
| order_i | input | 1 | Burst order: 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Beat present |
| last_o | output | 1 | Final beat of the burst |

## Verification
The bench uses start columns whose low bits are not zero. A design that reset the low bits to zero, or carried into the upper bits instead of wrapping, would emit addresses outside the aligned block. Sequential and interleaved bursts of 4 and 8 start from the same column, where the two orders give different sequences, so if the order bit were swapped the mismatch would show. Reserved codes are applied both while idle and in the middle of a burst, where a faulty design would start a burst or stop the running one. Restarts in mid-burst and on the final beat catch a design that finishes the old burst first or leaves a one-cycle gap. The mode inputs are changed after every start to expose a design that reads them live.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int unsigned LEN_CODE_W = 3;
  localparam int unsigned LOW_W      = 3;   // log2 of the largest burst
  localparam int unsigned LG_W       = 2;

  typedef enum logic [LEN_CODE_W-1:0] {
    LEN_2 = 3'b001,
    LEN_4 = 3'b010,
    LEN_8 = 3'b011
  } len_code_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_col_pkg::*;
(
  input  logic [LEN_CODE_W-1:0] code_i,
  output logic                  ok_o,
  output logic [LOW_W-1:0]      mask_o
);
  always_comb begin
    ok_o   = 1'b1;
    mask_o = '0;
    case (code_i)
      LEN_2:   mask_o = 3'b001;
      LEN_4:   mask_o = 3'b011;
      LEN_8:   mask_o = 3'b111;
      default: ok_o   = 1'b0;
    endcase
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_col_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LOW_W-1:0] mask_i,
  output logic [LOW_W-1:0] beat_o,
  output logic             active_o,
  output logic             last_o
);
  logic [LOW_W-1:0] mask_q;

  assign last_o = active_o && (beat_o == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_o   <= '0;
      active_o <= 1'b0;
      mask_q   <= '0;
    end else if (load_i) begin
      beat_o   <= '0;
      active_o <= 1'b1;
      mask_q   <= mask_i;
    end else if (active_o) begin
      if (last_o) begin
        active_o <= 1'b0;
        beat_o   <= '0;
      end else begin
        beat_o <= beat_o + 1'b1;
      end
    end
  end

  assign _unused_mask = mask_q;
  logic [LOW_W-1:0] _unused_mask;
endmodule

// File: rtl/burst_col_mix.sv
module burst_col_mix
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [LOW_W-1:0] beat_i,
  input  logic [LOW_W-1:0] mask_i,
  input  logic             order_i,
  output logic [COL_W-1:0] col_o
);
  logic [LOW_W-1:0] start_low, step_low, low;

  assign start_low = base_i[LOW_W-1:0];

  // sequential adds, interleaved xors; the mask keeps the wrap inside the block
  assign step_low = (order_i == ORD_ILV) ? (start_low ^ beat_i) : (start_low + beat_i);
  assign low      = (start_low & ~mask_i) | (step_low & mask_i);
  assign col_o    = {base_i[COL_W-1:LOW_W], low};
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  order_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  valid_o,
  output logic                  last_o
);
  logic             code_ok, load;
  logic [LOW_W-1:0] mask_d, mask_q, beat;
  logic [COL_W-1:0] base_q;
  logic             order_q;

  burst_len_decode u_dec (
    .code_i (len_code_i),
    .ok_o   (code_ok),
    .mask_o (mask_d)
  );

  assign load = start_i && code_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      order_q <= 1'b0;
      mask_q  <= '0;
    end else if (load) begin
      base_q  <= col_i;
      order_q <= order_i;
      mask_q  <= mask_d;
    end
  end

  burst_beat_ctr u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .mask_i   (mask_d),
    .beat_o   (beat),
    .active_o (valid_o),
    .last_o   (last_o)
  );

  burst_col_mix #(.COL_W(COL_W)) u_mix (
    .base_i  (base_q),
    .beat_i  (beat),
    .mask_i  (mask_q),
    .order_i (order_q),
    .col_o   (col_o)
  );
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] col_i,
  input logic [2:0]       len_code_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  logic accept;
  assign accept = start_i && (len_code_i inside {3'b001, 3'b010, 3'b011});

  // R8
  last_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  // R8
  stop_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !accept) |=> !valid_o);

  // R4
  first_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (valid_o && col_o == $past(col_i)));

  // R3
  reserved_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !accept) |=> !valid_o);

  // R7
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !accept) |=> (valid_o && col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .col_i      (col_i),
  .len_code_i (len_code_i),
  .col_o      (col_o),
  .valid_o    (valid_o),
  .last_o     (last_o)
);

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
  localparam int unsigned COL_W = 10;
  localparam time CLK_P = 10ns;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic [2:0]       len_code_i = 3'b000;
  logic             order_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  burst_col_gen #(.COL_W(COL_W)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int code_of(input int bl);
    return (bl == 2) ? 1 : (bl == 4) ? 2 : 3;
  endfunction

  function automatic int exp_col(input int s, input int bl, input int ord, input int k);
    int lo;
    lo = ord ? ((s % bl) ^ k) : (((s % bl) + k) % bl);
    return (s - (s % bl)) + lo;
  endfunction

  // caller is at a negedge; start lands on the next posedge
  task automatic launch(input int s, input int code, input int ord);
    start_i = 1'b1; col_i = COL_W'(s); len_code_i = 3'(code); order_i = ord[0];
  endtask

  // checks beats k0..k1-1, scrambling the mode inputs (R11)
  task automatic follow(input int s, input int bl, input int ord, input int k0, input int k1,
                        input string req);
    for (int k = k0; k < k1; k++) begin
      @(negedge clk_i);
      start_i = 1'b0; col_i = ~COL_W'(s); order_i = ~ord[0]; len_code_i = 3'(code_of(bl)) ^ 3'b001;
      chk({req, " valid"}, int'(valid_o), 1);
      chk({req, " col"}, int'(col_o), exp_col(s, bl, ord, k));
      chk({req, " last"}, int'(last_o), int'(k == bl - 1));
    end
  endtask

  task automatic expect_idle(input string req);
    @(negedge clk_i);
    chk({req, " valid low"}, int'(valid_o), 0);
    chk({req, " last low"}, int'(last_o), 0);
  endtask

  task automatic t_reset;
    chk("R1 valid in reset", int'(valid_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 valid after reset", int'(valid_o), 0);
    chk("R1 last after reset", int'(last_o), 0);
  endtask

  task automatic t_burst(input int s, input int bl, input int ord, input string req);
    @(negedge clk_i);
    launch(s, code_of(bl), ord);
    follow(s, bl, ord, 0, bl, req);
    expect_idle({req, " R2 R8 end"});
  endtask

  task automatic t_reserved_idle;
    int codes[3] = '{0, 4, 7};
    foreach (codes[i]) begin
      @(negedge clk_i);
      launch(9'h155, codes[i], 0);
      @(negedge clk_i); start_i = 1'b0;
      chk("R3 reserved idle", int'(valid_o), 0);
      @(negedge clk_i);
      chk("R3 reserved idle next", int'(valid_o), 0);
    end
  endtask

  task automatic t_reserved_mid;
    @(negedge clk_i);
    launch(10'h2D, 3, 0);
    follow(10'h2D, 8, 0, 0, 3, "R3 before");
    launch(10'h3F0, 5, 1);
    follow(10'h2D, 8, 0, 3, 8, "R3 reserved mid");
    expect_idle("R3 end");
  endtask

  task automatic t_restart_mid;
    @(negedge clk_i);
    launch(10'h113, 3, 0);
    follow(10'h113, 8, 0, 0, 3, "R9 first");
    launch(10'h26, 2, 1);
    follow(10'h26, 4, 1, 0, 4, "R9 restart");
    expect_idle("R9 end");
  endtask

  task automatic t_back_to_back;
    @(negedge clk_i);
    launch(10'h0B, 2, 0);
    follow(10'h0B, 4, 0, 0, 4, "R10 first");
    launch(10'h1C5, 1, 1);
    follow(10'h1C5, 2, 1, 0, 2, "R10 second");
    expect_idle("R10 end");
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_burst(10'h2D, 2, 0, "R2 R5 seq2");
    t_burst(10'h2D, 4, 0, "R5 seq4");
    t_burst(10'h2D, 8, 0, "R5 R7 seq8");
    t_burst(10'h2D, 2, 1, "R6 ilv2");
    t_burst(10'h2D, 4, 1, "R6 ilv4");
    t_burst(10'h2D, 8, 1, "R6 R7 ilv8");
    t_burst(10'h3FE, 8, 0, "R4 R11 seq8 top");
    t_reserved_idle();
    t_reserved_mid();
    t_restart_mid();
    t_back_to_back();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule